// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block takes in asynchronous serial frames from a single data line. It uses a 16x oversampling tick to find a start bit and to sample each bit at its centre. It gathers the data bits least significant bit first. It can check a parity bit, and it checks the stop bit. Each finished frame is passed to a host-visible data register together with status flags.

The data length, parity enable, odd or even parity, and one or two stop bits are chosen by static configuration inputs.

The host sees four flags:
- a data-full flag;
- an overrun flag;
- a framing flag;
- a parity flag.

Each error condition has its own rule for whether the data register is written. While any error flag is set, the receiver accepts no new frame. The host clears the data-full flag with one strobe and all error flags with a second strobe. When receive interrupts are enabled, two interrupt outputs report a received character and a receive error.

Top module: `serial_rx_core`

## Requirements
- R1: Reception starts only when the idle receiver sees the line low on a tick. The start bit is confirmed by a second low sample half a bit later. A low pulse shorter than half a bit returns the receiver to idle and changes no output.
- R2: Data bits are taken least significant bit first. With `cfg_short`=0 there are 8 data bits; with `cfg_short`=1 there are 7, and bit 7 of `rx_data` reads 0.
- R3: With `cfg_par_en`=1, one parity bit follows the data. Over the data bits plus the parity bit, the count of 1s must be even when `cfg_par_odd`=0 and odd when `cfg_par_odd`=1. A mismatch sets `err_parity`.
- R4: A first stop bit of 0 sets `err_frame`. With `cfg_stop2`=1, the second stop bit is not checked.
- R5: A frame that passes all checks while `rx_full`=0 writes its data to `rx_data` and sets `rx_full`.
- R6: A frame that ends while `rx_full`=1 sets `err_overrun` and leaves `rx_data` unchanged.
- R7: A frame with a framing or parity error, ending while `rx_full`=0, still writes `rx_data` but leaves `rx_full` at 0.
- R8: While any error flag is 1, arriving frames are ignored: `rx_data` and all flags keep their values.
- R9: `clr_full` clears `rx_full` on the next clock. `clr_err` clears all three error flags on the next clock.
- R10: `irq_rx_end` equals `rx_full` AND `cfg_irq_en`. `irq_rx_err` equals (any error flag) AND `cfg_irq_en`.
- R11: After reset, `rx_data` is 0 and all flags and interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial data line, idle high |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| cfg_short | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop2 | input | 1 | Two stop bits per frame |
| cfg_irq_en | input | 1 | Receive interrupt enable |
| clr_full | input | 1 | Strobe that clears the data-full flag |
| clr_err | input | 1 | Strobe that clears all error flags |
| rx_data | output | 8 | Receive data register |
| rx_full | output | 1 | Data-full flag |
| err_overrun | output | 1 | Overrun error flag |
| err_frame | output | 1 | Framing error flag |
| err_parity | output | 1 | Parity error flag |
| irq_rx_end | output | 1 | Receive-end interrupt |
| irq_rx_err | output | 1 | Receive-error interrupt |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit, 8-bit data and a two-stage synchronizer. It drives one tick every second clock, so a bit lasts 32 clocks, and a complete frame plus one idle bit takes under 450 clocks.

Frames are short, so all 16 combinations of length, parity enable, parity sense and stop count can be swept, each with several data patterns including all-zeros and all-ones. The expected parity and the 7-bit masking are computed in the bench. The same budget covers:
- the error-ordering cases: overrun against a full register, parity error, framing error, and reception held off;
- the unchecked second stop bit;
- a start glitch.

// File: rtl/srx_pkg.sv
package srx_pkg;
   typedef enum logic [2:0] {
      SRX_IDLE,
      SRX_START,
      SRX_DATA,
      SRX_PAR,
      SRX_STOP1,
      SRX_STOP2
   } srx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= RST_VAL;
            else        chain <= d;
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer #(
   parameter int OVS = 16,
   parameter int DW  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          os_tick,
   input  logic          rx_s,
   input  logic          halt,
   input  logic          cfg_short,
   input  logic          cfg_par_en,
   input  logic          cfg_par_odd,
   input  logic          cfg_stop2,
   output logic          done,
   output logic [DW-1:0] data,
   output logic          par_bad,
   output logic          stop_bad
);
   import srx_pkg::*;

   localparam int CW = $clog2(OVS);
   localparam int IW = $clog2(DW);
   localparam int BW = $clog2(DW + 1);
   localparam logic [CW-1:0] MID_C  = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] LAST_C = CW'(OVS - 1);

   srx_state_e    st;
   logic [CW-1:0] cnt;
   logic [BW-1:0] bidx;
   logic [BW-1:0] nbits;
   logic [DW-1:0] shreg;
   logic          pbit;
   logic          done_q, pb_q, sb_q;
   logic          at_last;

   assign nbits   = cfg_short ? BW'(DW - 1) : BW'(DW);
   assign at_last = os_tick && (cnt == LAST_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SRX_IDLE;
         cnt    <= '0;
         bidx   <= '0;
         shreg  <= '0;
         pbit   <= 1'b0;
         done_q <= 1'b0;
         pb_q   <= 1'b0;
         sb_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (os_tick && !at_last && st != SRX_IDLE)
            cnt <= cnt + 1'b1;
         case (st)
            SRX_IDLE:
               if (os_tick && !halt && !rx_s) begin
                  st  <= SRX_START;
                  cnt <= '0;
               end
            SRX_START:
               if (os_tick && cnt == MID_C) begin
                  cnt <= '0;
                  if (!rx_s) begin
                     st    <= SRX_DATA;
                     bidx  <= '0;
                     shreg <= '0;
                  end else begin
                     st <= SRX_IDLE;
                  end
               end
            SRX_DATA:
               if (at_last) begin
                  cnt <= '0;
                  shreg[bidx[IW-1:0]] <= rx_s;
                  bidx <= bidx + 1'b1;
                  if (bidx == nbits - 1'b1)
                     st <= cfg_par_en ? SRX_PAR : SRX_STOP1;
               end
            SRX_PAR:
               if (at_last) begin
                  cnt  <= '0;
                  pbit <= rx_s;
                  st   <= SRX_STOP1;
               end
            SRX_STOP1:
               if (at_last) begin
                  cnt    <= '0;
                  done_q <= 1'b1;
                  sb_q   <= !rx_s;
                  pb_q   <= cfg_par_en && (((^shreg) ^ pbit) != cfg_par_odd);
                  st     <= cfg_stop2 ? SRX_STOP2 : SRX_IDLE;
               end
            SRX_STOP2:
               if (at_last) begin
                  cnt <= '0;
                  st  <= SRX_IDLE;
               end
            default: st <= SRX_IDLE;
         endcase
      end
   end

   assign done     = done_q;
   assign data     = shreg;
   assign par_bad  = pb_q;
   assign stop_bad = sb_q;

   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   assert_short_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && cfg_short) |-> !shreg[DW-1]);
   assert_halt_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && st == SRX_IDLE) |=> st == SRX_IDLE);
endmodule

// File: rtl/srx_status.sv
module srx_status #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          done,
   input  logic [DW-1:0] data_in,
   input  logic          par_bad,
   input  logic          stop_bad,
   input  logic          clr_full,
   input  logic          clr_err,
   input  logic          irq_en,
   output logic [DW-1:0] data_q,
   output logic          full_q,
   output logic          ovr_q,
   output logic          fer_q,
   output logic          per_q,
   output logic          halt,
   output logic          irq_end,
   output logic          irq_err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         full_q <= 1'b0;
         ovr_q  <= 1'b0;
         fer_q  <= 1'b0;
         per_q  <= 1'b0;
      end else begin
         if (clr_full) full_q <= 1'b0;
         if (clr_err) begin
            ovr_q <= 1'b0;
            fer_q <= 1'b0;
            per_q <= 1'b0;
         end
         if (done) begin
            if (full_q) begin
               ovr_q <= 1'b1;
            end else begin
               data_q <= data_in;
               if (par_bad)  per_q <= 1'b1;
               if (stop_bad) fer_q <= 1'b1;
               if (!par_bad && !stop_bad) full_q <= 1'b1;
            end
         end
      end
   end

   assign halt    = ovr_q | fer_q | per_q;
   assign irq_end = full_q & irq_en;
   assign irq_err = halt & irq_en;

   assert_overrun_keeps_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> $stable(data_q));
   assert_error_no_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(fer_q) || $rose(per_q)) |-> !$rose(full_q));
   assert_clear_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_full && !done) |=> !full_q);
   assert_halt_no_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !clr_err) |=> $stable(data_q));
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
   parameter int OVS         = 16,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_line,
   input  logic          os_tick,
   input  logic          cfg_short,
   input  logic          cfg_par_en,
   input  logic          cfg_par_odd,
   input  logic          cfg_stop2,
   input  logic          cfg_irq_en,
   input  logic          clr_full,
   input  logic          clr_err,
   output logic [DW-1:0] rx_data,
   output logic          rx_full,
   output logic          err_overrun,
   output logic          err_frame,
   output logic          err_parity,
   output logic          irq_rx_end,
   output logic          irq_rx_err
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (DW < 2) begin : g_bad_dw
         $error("DW must be at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic          rx_s;
   logic          halt;
   logic          done;
   logic          par_bad, stop_bad;
   logic [DW-1:0] frame_data;

   srx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_line),
      .q     (rx_s)
   );

   srx_framer #(.OVS(OVS), .DW(DW)) u_framer (
      .clk         (clk),
      .rst_n       (rst_n),
      .os_tick     (os_tick),
      .rx_s        (rx_s),
      .halt        (halt),
      .cfg_short   (cfg_short),
      .cfg_par_en  (cfg_par_en),
      .cfg_par_odd (cfg_par_odd),
      .cfg_stop2   (cfg_stop2),
      .done        (done),
      .data        (frame_data),
      .par_bad     (par_bad),
      .stop_bad    (stop_bad)
   );

   srx_status #(.DW(DW)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (done),
      .data_in  (frame_data),
      .par_bad  (par_bad),
      .stop_bad (stop_bad),
      .clr_full (clr_full),
      .clr_err  (clr_err),
      .irq_en   (cfg_irq_en),
      .data_q   (rx_data),
      .full_q   (rx_full),
      .ovr_q    (err_overrun),
      .fer_q    (err_frame),
      .per_q    (err_parity),
      .halt     (halt),
      .irq_end  (irq_rx_end),
      .irq_err  (irq_rx_err)
   );
endmodule

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb;
   localparam int BIT = 32;   // 16 ticks x 2 clocks

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_line = 1'b1;
   logic       os_tick = 1'b0;
   logic       cfg_short = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
   logic       cfg_stop2 = 1'b0, cfg_irq_en = 1'b0;
   logic       clr_full = 1'b0, clr_err = 1'b0;
   logic [7:0] rx_data;
   logic       rx_full, err_overrun, err_frame, err_parity;
   logic       irq_rx_end, irq_rx_err;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   serial_rx_core u_dut (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
      .cfg_short(cfg_short), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_stop2(cfg_stop2), .cfg_irq_en(cfg_irq_en),
      .clr_full(clr_full), .clr_err(clr_err),
      .rx_data(rx_data), .rx_full(rx_full), .err_overrun(err_overrun),
      .err_frame(err_frame), .err_parity(err_parity),
      .irq_rx_end(irq_rx_end), .irq_rx_err(irq_rx_err)
   );

   always #2.5 clk = ~clk;

   initial forever begin
      @(negedge clk);
      os_tick = ~os_tick;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic hold_line(input logic v, input int clocks);
      rx_line = v;
      repeat (clocks) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] d, input bit bad_par,
                             input logic stop1, input logic stop2v);
      int nb = cfg_short ? 7 : 8;
      logic [7:0] dm = cfg_short ? (d & 8'h7F) : d;
      hold_line(1'b0, BIT);
      for (int i = 0; i < nb; i++) hold_line(d[i], BIT);
      if (cfg_par_en) hold_line((^dm) ^ cfg_par_odd ^ bad_par, BIT);
      hold_line(stop1, BIT);
      if (cfg_stop2) hold_line(stop2v, BIT);
      hold_line(1'b1, BIT);
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_full();
      clr_full = 1'b1; @(negedge clk); clr_full = 1'b0;
   endtask

   task automatic pulse_err();
      clr_err = 1'b1; @(negedge clk); clr_err = 1'b0;
   endtask

   function automatic logic [3:0] errs();
      return {1'b0, err_overrun, err_frame, err_parity};
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] d, exp_d;
      repeat (5) @(negedge clk);
      // R11: reset state
      chk("R11 data", rx_data, 0);
      chk("R11 flags", {rx_full, err_overrun, err_frame, err_parity, irq_rx_end, irq_rx_err}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // Sweep of all configurations: R2 R3 R5 R9 R10
      for (int cfg = 0; cfg < 16; cfg++) begin
         {cfg_stop2, cfg_par_odd, cfg_par_en, cfg_short} = cfg[3:0];
         for (int k = 0; k < 6; k++) begin
            d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((k * 53 + cfg * 17 + 1) & 8'hFF);
            cfg_irq_en = k[0];
            exp_d = cfg_short ? (d & 8'h7F) : d;
            send_frame(d, 1'b0, 1'b1, 1'b1);
            chk("R2 data order", rx_data, exp_d);
            chk("R5 full set", rx_full, 1);
            chk("R3 no error on good frame", errs(), 0);
            chk("R10 irq_rx_end", irq_rx_end, cfg_irq_en);
            chk("R10 irq_rx_err idle", irq_rx_err, 0);
            pulse_full();
            chk("R9 clr_full", rx_full, 0);
         end
      end

      // Error handling: 8-bit, even parity, one stop bit, interrupts on
      {cfg_stop2, cfg_par_odd, cfg_par_en, cfg_short} = 4'b0010;
      cfg_irq_en = 1'b1;
      send_frame(8'h5A, 1'b1, 1'b1, 1'b1);
      chk("R3 parity flag", err_parity, 1);
      chk("R7 data loaded on parity error", rx_data, 8'h5A);
      chk("R7 full stays 0", rx_full, 0);
      chk("R10 irq_rx_err", irq_rx_err, 1);

      send_frame(8'h33, 1'b0, 1'b1, 1'b1);
      chk("R8 halted data", rx_data, 8'h5A);
      chk("R8 halted flags", {rx_full, errs()}, 5'b0_0001);

      pulse_err();
      chk("R9 clr_err", errs(), 0);
      chk("R10 irq_rx_err cleared", irq_rx_err, 0);
      send_frame(8'h33, 1'b0, 1'b1, 1'b1);
      chk("R5 after clear", {rx_full, rx_data}, {1'b1, 8'h33});

      send_frame(8'h44, 1'b0, 1'b1, 1'b1);
      chk("R6 overrun flag", err_overrun, 1);
      chk("R6 data kept", rx_data, 8'h33);
      chk("R6 full kept", rx_full, 1);
      pulse_full();
      pulse_err();

      // Odd parity mismatch
      cfg_par_odd = 1'b1;
      send_frame(8'h0F, 1'b1, 1'b1, 1'b1);
      chk("R3 odd parity flag", {err_parity, rx_full, rx_data}, {1'b1, 1'b0, 8'h0F});
      pulse_err();

      // Framing error, no parity
      cfg_par_en = 1'b0;
      send_frame(8'h81, 1'b0, 1'b0, 1'b1);
      chk("R4 framing flag", err_frame, 1);
      chk("R7 data loaded on framing error", {rx_full, rx_data}, {1'b0, 8'h81});
      pulse_err();

      // Second stop bit not checked
      cfg_stop2 = 1'b1;
      send_frame(8'hC3, 1'b0, 1'b1, 1'b0);
      chk("R4 second stop ignored", {rx_full, errs(), rx_data}, {1'b1, 4'h0, 8'hC3});
      pulse_full();

      // Start glitch shorter than half a bit
      cfg_stop2 = 1'b0;
      hold_line(1'b0, 8);
      hold_line(1'b1, 3 * BIT);
      chk("R1 glitch ignored", {rx_full, errs(), rx_data}, {1'b0, 4'h0, 8'hC3});
      send_frame(8'h96, 1'b0, 1'b1, 1'b1);
      chk("R1 receives after glitch", {rx_full, rx_data}, {1'b1, 8'h96});

      finish_run();
   end
endmodule